// File: doc/BRIEF.md
# Keystream Rate Buffer

This block sits between a decimating keystream stage, which emits bits at an irregular rate, and the keystream output, which must run at a steady rate. Every bit the decimator emits is written into a 32-entry single-bit first-in first-out queue. The output side ignores any consumer handshake. It pops one bit for every fourth shift tick of the feeding register, so the output rate is a fixed fraction of the shift rate.

After `enable` rises the queue starts empty and no keystream leaves the block. Output begins only once the queue has filled completely for the first time. From then on a modulo-4 counter of shift ticks sets the read slots. A new bit that arrives when the queue is full and no read is due is discarded. A read slot that finds the queue empty produces no valid bit and sets a sticky error flag. Taking `enable` low flushes the queue and returns the block to its start state.

Top module: `ks_rate_buffer`

## Requirements
- R1: After reset, and in every cycle after a cycle with `enable` low, `occupancy` is 0, `q_empty` is 1, and `q_full`, `primed`, `ks_valid`, `underflow_err` and `dropped` are all 0.
- R2: When `enable` is high, a `dec_valid` cycle on a queue that is not full stores `dec_bit` and raises `occupancy` by one at the next edge. `q_full` is 1 exactly when `occupancy` is 32.
- R3: A `dec_valid` cycle while the queue is full, with no read slot in that cycle, discards the bit. `occupancy` stays 32 and `dropped` is 1 for the following cycle only.
- R4: `ks_valid` stays 0 whatever `shift_tick` does until the queue has held 32 bits after the latest start.
- R5: `primed` rises in the cycle after the first cycle with `occupancy` equal to 32. From then on the shift ticks are counted modulo 4 starting at zero. Every fourth tick is a read slot, and `ks_valid` is 1 for exactly the one cycle after a read slot edge whenever the queue held a bit.
- R6: Bits leave on `ks_bit` in the same order they were accepted.
- R7: A write in the same cycle as a read slot on a full queue is accepted. `dropped` stays 0 and `occupancy` remains 32.
- R8: A read slot with an empty queue leaves `ks_valid` at 0 and sets `underflow_err`. The flag stays set until reset or `enable` goes low.
- R9: Once set, `primed` stays set while `enable` is high, even after the queue drains or underflows, and read slots keep their cadence.
- R10: Dropping `enable` for one cycle clears the queue and the primed state. After re-enabling, no keystream appears until the queue fills again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | High while the keystream loop runs; low flushes the block |
| dec_valid | input | 1 | Decimator emits a bit this cycle |
| dec_bit | input | 1 | Bit emitted by the decimator |
| shift_tick | input | 1 | One shift of the feeding register this cycle |
| ks_bit | output | 1 | Keystream bit, meaningful when `ks_valid` is 1 |
| ks_valid | output | 1 | One-cycle strobe for a delivered keystream bit |
| occupancy | output | 6 | Number of bits held, 0 to 32 |
| q_full | output | 1 | Queue holds 32 bits |
| q_empty | output | 1 | Queue holds no bits |
| primed | output | 1 | Queue has filled since the latest start; output cadence is running |
| underflow_err | output | 1 | Sticky: a read slot found the queue empty |
| dropped | output | 1 | One-cycle pulse: an incoming bit was discarded |

## Verification
The bench drives ticks throughout the fill phase. A design that opened its output early would emit bits before `primed`. The bench lines up a write with a read slot on a full queue. A design that checked fullness before serving the read would wrongly discard that bit and pulse `dropped`. It drains the queue through the exact slot that finds it empty. Off-by-one errors in the cadence counter would show as a wrong count of valid strobes, and a non-sticky error flag would clear once new bits arrive. A reference queue in the bench tracks every accepted bit, so a wrap fault in a pointer appears as a reordered or corrupted `ks_bit`.

// File: rtl/ksbuf_pkg.sv
// Shared definitions for the keystream rate buffer.
// Holds the default sizing and the queue operation encoding used by the storage module.
package ksbuf_pkg;

    localparam int KB_DEPTH_DEFAULT   = 32;
    localparam int KB_CADENCE_DEFAULT = 4;

    // Operation applied to the queue in one cycle.
    typedef enum logic [1:0] {
        Q_HOLD = 2'b00,
        Q_PUSH = 2'b01,
        Q_POP  = 2'b10,
        Q_SWAP = 2'b11
    } q_op_e;

endpackage

// File: rtl/ks_bitq.sv
// Single-bit circular queue with occupancy count.
// The pop is served before the push, so a push on a full queue succeeds when a pop
// happens in the same cycle. A pop on an empty queue is ignored. Assumes DEPTH >= 2.
module ks_bitq
    import ksbuf_pkg::*;
#(
    parameter int DEPTH = KB_DEPTH_DEFAULT,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          din,
    input  logic          pop,
    output logic          dout,
    output logic          accepted,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [DEPTH-1:0] mem;
    logic [PW-1:0]    rd_ptr;
    logic [PW-1:0]    wr_ptr;
    logic             pop_ok;
    q_op_e            op;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign dout  = mem[rd_ptr];

    // Decide which accesses take effect this cycle: the read goes first.
    always_comb begin
        pop_ok   = pop && !empty;
        accepted = push && (!full || pop_ok);
        op       = q_op_e'({pop_ok, accepted});
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            case (op)
                Q_PUSH: begin
                    wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
                    count  <= count + 1'b1;
                end
                Q_POP: begin
                    rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
                    count  <= count - 1'b1;
                end
                Q_SWAP: begin
                    wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
                    rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Store an accepted bit at the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (accepted && !flush) begin
            mem[wr_ptr] <= din;
        end
    end

    // R2: the occupancy never exceeds the depth.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R3: a lone push on a full queue leaves it full.
    a_r3_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> full);

    // R7: push and pop together on a full queue leave it full.
    a_r7_swap_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && full && !flush) |=> full);

endmodule

// File: rtl/ks_cadence.sv
// Read-slot generator: counts shift ticks modulo CADENCE while running and marks
// every CADENCE-th tick as a read slot. The count restarts at zero whenever
// the run input is low.
module ks_cadence
    import ksbuf_pkg::*;
#(
    parameter int CADENCE = KB_CADENCE_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic slot
);

    generate
        if (CADENCE <= 1) begin : g_every_tick
            // Every tick is a slot; no counter is needed.
            assign slot = run && tick;
        end else begin : g_counted
            localparam int PHW = $clog2(CADENCE);
            logic [PHW-1:0] phase;

            assign slot = run && tick && (phase == PHW'(CADENCE - 1));

            // Count ticks while running, wrapping at the slot.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    phase <= '0;
                end else if (tick) begin
                    phase <= slot ? '0 : phase + 1'b1;
                end
            end

            // R5: two read slots are never back to back.
            a_r5_slot_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                slot |=> !slot);
        end
    endgenerate

endmodule

// File: rtl/ks_rate_buffer.sv
// Keystream rate buffer: queues decimator bits and releases one per CADENCE
// shift ticks once the queue has filled after the latest start. Overflowing bits
// are discarded; a slot that finds the queue empty sets a sticky error flag.
// Assumes enable stays high for the whole keystream run and that low enable flushes.
module ks_rate_buffer
    import ksbuf_pkg::*;
#(
    parameter int DEPTH   = KB_DEPTH_DEFAULT,
    parameter int CADENCE = KB_CADENCE_DEFAULT,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          dec_valid,
    input  logic          dec_bit,
    input  logic          shift_tick,
    output logic          ks_bit,
    output logic          ks_valid,
    output logic [CW-1:0] occupancy,
    output logic          q_full,
    output logic          q_empty,
    output logic          primed,
    output logic          underflow_err,
    output logic          dropped
);

    logic push;
    logic slot;
    logic head_bit;
    logic accepted;

    assign push = enable && dec_valid;

    ks_bitq #(.DEPTH(DEPTH)) queue_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (!enable),
        .push     (push),
        .din      (dec_bit),
        .pop      (slot),
        .dout     (head_bit),
        .accepted (accepted),
        .count    (occupancy),
        .full     (q_full),
        .empty    (q_empty)
    );

    ks_cadence #(.CADENCE(CADENCE)) cadence_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (primed),
        .tick  (shift_tick),
        .slot  (slot)
    );

    // Latch the first time the queue is seen full after a start.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            primed <= 1'b0;
        end else if (q_full) begin
            primed <= 1'b1;
        end
    end

    // Register the delivered bit, the underflow flag and the drop pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            ks_bit        <= 1'b0;
            ks_valid      <= 1'b0;
            underflow_err <= 1'b0;
            dropped       <= 1'b0;
        end else begin
            ks_valid <= slot && !q_empty;
            dropped  <= push && !accepted;
            if (slot && !q_empty) begin
                ks_bit <= head_bit;
            end
            if (slot && q_empty) begin
                underflow_err <= 1'b1;
            end
        end
    end

    // R4: no keystream leaves before the queue has filled.
    a_r4_quiet_until_primed: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |-> !ks_valid);

    // R8: the underflow flag holds while enabled.
    a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_err && enable) |=> underflow_err);

    // R9: primed holds while enabled.
    a_r9_primed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && enable) |=> primed);

    // R3: a drop pulse only follows a cycle where the queue was full.
    a_r3_drop_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dropped) |-> $past(q_full));

endmodule

// File: tb/ks_rate_buffer_tb.sv
// Directed bench for the keystream rate buffer; a reference queue supplies expected bits.
module ks_rate_buffer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       dec_valid = 1'b0;
    logic       dec_bit = 1'b0;
    logic       shift_tick = 1'b0;
    logic       ks_bit;
    logic       ks_valid;
    logic [5:0] occupancy;
    logic       q_full;
    logic       q_empty;
    logic       primed;
    logic       underflow_err;
    logic       dropped;

    int checks = 0;
    int failures = 0;
    int valid_seen = 0;
    bit done = 0;

    bit       mq[$];
    bit       m_primed = 0;
    int       m_phase = 0;
    bit       m_under = 0;
    logic [7:0] lf = 8'hA5;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ks_rate_buffer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .dec_valid     (dec_valid),
        .dec_bit       (dec_bit),
        .shift_tick    (shift_tick),
        .ks_bit        (ks_bit),
        .ks_valid      (ks_valid),
        .occupancy     (occupancy),
        .q_full        (q_full),
        .q_empty       (q_empty),
        .primed        (primed),
        .underflow_err (underflow_err),
        .dropped       (dropped)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic bit next_bit();
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        return lf[0];
    endfunction

    // One clock: drive inputs, advance the reference model, compare after the edge.
    task automatic step(input bit wr, input bit tick);
        bit b;
        bit ev;
        bit eb;
        bit ed;
        bit slot_now;
        int old_size;
        b = next_bit();
        ev = 0; eb = 0; ed = 0;
        dec_valid  = wr;
        dec_bit    = b;
        shift_tick = tick;
        old_size   = mq.size();
        if (!enable) begin
            mq.delete();
            m_primed = 0; m_phase = 0; m_under = 0;
        end else begin
            slot_now = m_primed && tick && (m_phase == 3);
            if (slot_now) begin
                if (mq.size() > 0) begin ev = 1; eb = mq.pop_front(); end
                else m_under = 1;
            end
            if (wr) begin
                if (mq.size() < DEPTH) mq.push_back(b);
                else ed = 1;
            end
            if (m_primed && tick) m_phase = (m_phase + 1) % 4;
            if (old_size == DEPTH) m_primed = 1;
        end
        @(posedge clk);
        #1;
        if (ks_valid) valid_seen++;
        check("R5 ks_valid", int'(ks_valid), int'(ev));
        if (ev) check("R6 ks_bit order", int'(ks_bit), int'(eb));
        check("R2 occupancy", int'(occupancy), mq.size());
        check("R3 dropped", int'(dropped), int'(ed));
        check("R8 underflow_err", int'(underflow_err), int'(m_under));
        check("R9 primed", int'(primed), int'(m_primed));
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        check("R1 occupancy", int'(occupancy), 0);
        check("R1 q_empty", int'(q_empty), 1);
        check("R1 q_full", int'(q_full), 0);
        check("R1 primed", int'(primed), 0);
        check("R1 ks_valid", int'(ks_valid), 0);
        check("R1 underflow_err", int'(underflow_err), 0);
        check("R1 dropped", int'(dropped), 0);
    endtask

    task automatic t_prefill();
        enable = 1;
        valid_seen = 0;
        for (int i = 0; i < DEPTH - 1; i++) step(1, 1);
        check("R4 no output before fill", valid_seen, 0);
        check("R2 occupancy 31", int'(occupancy), 31);
        check("R2 not full at 31", int'(q_full), 0);
    endtask

    task automatic t_fill();
        step(1, 1);
        check("R2 full at 32", int'(q_full), 1);
        check("R5 primed waits one cycle", int'(primed), 0);
        check("R4 still quiet", valid_seen, 0);
        step(0, 0);
        check("R5 primed after full", int'(primed), 1);
    endtask

    task automatic t_overflow();
        step(1, 0);
        check("R3 drop pulse", int'(dropped), 1);
        check("R3 occupancy stays 32", int'(occupancy), 32);
        step(0, 0);
        check("R3 drop pulse single", int'(dropped), 0);
    endtask

    task automatic t_simultaneous();
        valid_seen = 0;
        for (int i = 0; i < 3; i++) step(0, 1);
        check("R5 no read before 4th tick", valid_seen, 0);
        step(1, 1);
        check("R7 read served", int'(ks_valid), 1);
        check("R7 write accepted", int'(dropped), 0);
        check("R7 occupancy 32", int'(occupancy), 32);
    endtask

    task automatic t_cadence();
        valid_seen = 0;
        for (int i = 0; i < 40; i++) begin
            step(0, 1);
            if (i % 5 == 2) step(0, 0);
        end
        check("R5 ten reads in forty ticks", valid_seen, 10);
        check("R9 primed while not full", int'(primed) & int'(!q_full), 1);
        check("R2 occupancy 22", int'(occupancy), 22);
    endtask

    task automatic t_underflow();
        valid_seen = 0;
        for (int i = 0; i < 88; i++) step(0, 1);
        check("R5 drained reads", valid_seen, 22);
        check("R8 no error yet", int'(underflow_err), 0);
        valid_seen = 0;
        for (int i = 0; i < 4; i++) step(0, 1);
        check("R8 empty slot not valid", valid_seen, 0);
        check("R8 error set", int'(underflow_err), 1);
        valid_seen = 0;
        for (int i = 0; i < 8; i++) step(1, 1);
        check("R9 reads resume after underflow", valid_seen, 2);
        check("R8 error sticky", int'(underflow_err), 1);
    endtask

    task automatic t_disable();
        enable = 0;
        step(0, 1);
        check("R10 occupancy cleared", int'(occupancy), 0);
        check("R10 primed cleared", int'(primed), 0);
        check("R10 error cleared", int'(underflow_err), 0);
        check("R1 empty after disable", int'(q_empty), 1);
        enable = 1;
        valid_seen = 0;
        for (int i = 0; i < 8; i++) step(1, 1);
        check("R10 quiet after restart", valid_seen, 0);
        check("R10 refill count", int'(occupancy), 8);
    endtask

    initial begin
        #1;
        t_reset();
        t_prefill();
        t_fill();
        t_overflow();
        t_simultaneous();
        t_cadence();
        t_underflow();
        t_disable();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end

endmodule